// File: doc/BRIEF.md
# Indirect-Access Interrupt Redirection Controller

This block routes numbered interrupt lines to processor targets through a programmable redirection table. Software reaches every internal register through only two bus offsets. It first writes an internal index into a selector register. It then reads or writes the chosen register through a data window. The internal registers are an identification word, a read-only version word, a read-only arbitration word that always reads zero, and one 64-bit redirection entry per line. Each entry is reached as two 32-bit halves at consecutive indices.

When a line requests service, the block fetches that line's entry. One cycle later it issues a single-cycle delivery pulse carrying an 8-bit vector and a destination mask. The mask depends on a mode bit in the entry. In physical mode, a 4-bit target number is decoded into a one-hot mask. In logical mode, an 8-bit field is passed through unchanged. Requests on lines with no entry are refused with an error pulse. Every bus access gets a registered response one cycle after it is presented.

Top module: `irq_route_ctrl`

## Requirements
- R1: After reset, the selector, the identification word and every table half read as zero.
- R2: Only offset 0x00 (selector) and offset 0x10 (data window) are decoded. Any other offset gives an error response with zero read data, and no state changes.
- R3: Writing a value above 255 to the selector gives an error response, and the selector keeps its previous value.
- R4: Internal index 0x00 is the identification word. All 32 bits can be written and read back.
- R5: Internal index 0x01 reads (NUM_ENTRIES-1) in bits 23:16 and 0x11 in bits 7:0, which is 0x00170011 for 24 entries. A write to it gives a non-error response and changes nothing.
- R6: Internal index 0x02 always reads zero. A write to it gives a non-error response and changes nothing.
- R7: Internal index 0x10+2n selects the low half of entry n, and index 0x11+2n selects the high half. The two halves are stored independently.
- R8: Any internal index other than 0x00-0x02 and 0x10 through 0x10+2*NUM_ENTRIES-1 gives an error response through the window, and no state changes.
- R9: A request on line L < NUM_ENTRIES produces a delivery pulse in the next cycle. The pulse carries the vector from bits 7:0 of entry L's low half, and the irq error flag stays low.
- R10: When bit 11 of the low half is 0 (physical), the destination mask is 1 << high[27:24]. Bits 31:28 of the high half are ignored.
- R11: When bit 11 of the low half is 1 (logical), the destination mask is high[31:24], zero-extended.
- R12: A request on a line >= NUM_ENTRIES gives a one-cycle irq error pulse in the next cycle and no delivery.
- R13: If a window write and a request hit the same entry in the same cycle, the delivery uses the entry's contents from before the write.
- R14: Every bus access gets exactly one response cycle (respValid high), in the cycle after the access. respValid is low in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busValid | input | 1 | Bus access present this cycle |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | 8 | Bus offset (0x00 selector, 0x10 window) |
| busWdata | input | 32 | Write data |
| respValid | output | 1 | Response cycle |
| respErr | output | 1 | Access refused |
| respData | output | 32 | Read data (zero on writes and errors) |
| irqValid | input | 1 | Interrupt request present |
| irqLine | input | 8 | Requesting line number |
| dlvValid | output | 1 | Delivery pulse |
| dlvVector | output | 8 | Delivered vector |
| dlvDest | output | 16 | Destination mask |
| irqErr | output | 1 | Request on a line with no entry |

## Verification
The bench targets the edges of the index map: 0x02 against 0x03, the last entry's high half at 0x3F, and the first unmapped index 0x40. A decoder off by one would either error on the last entry or accept a phantom one. It also writes stray bits above 27 into a physical-mode high half. A design that decoded too wide a field would produce a zero or wrong mask. Another check writes and requests the same entry in one cycle. A design that forwarded the write would deliver the new vector early. The last group of checks confirms that refused selector writes and writes to read-only words leave every readable value unchanged.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;

  typedef enum logic [2:0] {
    SRC_NONE,
    SRC_SEL,
    SRC_ID,
    SRC_VER,
    SRC_ZERO,
    SRC_TBL
  } rdSrc_e;

  // Strobes from the control decoder to the datapath, one cycle's worth.
  typedef struct packed {
    logic       rspValid;
    logic       rspErr;
    rdSrc_e     rdSrc;
    logic       selWr;
    logic       idWr;
    logic       tblWr;
    logic       tblHi;
    logic [7:0] tblIdx;
    logic       lookup;
    logic [7:0] lookupIdx;
    logic       irqErr;
  } ctrlStb_t;

  localparam logic [7:0] OFF_SELECT = 8'h00;
  localparam logic [7:0] OFF_WINDOW = 8'h10;
  localparam logic [7:0] IDX_ID     = 8'h00;
  localparam logic [7:0] IDX_VER    = 8'h01;
  localparam logic [7:0] IDX_ARB    = 8'h02;
  localparam logic [7:0] IDX_TBL0   = 8'h10;
  localparam logic [7:0] VER_CODE   = 8'h11;

endpackage

// File: rtl/irq_route_decode.sv
module irq_route_decode
  import irq_route_pkg::*;
#(
  parameter int NUM_ENTRIES = 24
) (
  input  logic        busValid,
  input  logic        busWrite,
  input  logic [7:0]  busAddr,
  input  logic [31:0] busWdata,
  input  logic [7:0]  selCur,
  input  logic        irqValid,
  input  logic [7:0]  irqLine,
  output ctrlStb_t    stb
);

  localparam int LAST_IDX = 16 + 2 * NUM_ENTRIES - 1;

  logic [7:0] tblOff;
  logic       inTable;

  assign tblOff  = selCur - IDX_TBL0;
  assign inTable = (selCur >= IDX_TBL0) && (32'(selCur) <= LAST_IDX);

  always_comb begin
    stb = '0;
    stb.rdSrc = SRC_NONE;
    stb.rspValid = busValid;
    if (busValid) begin
      if (busAddr == OFF_SELECT) begin
        if (busWrite) begin
          if (busWdata > 32'd255) stb.rspErr = 1'b1;
          else                    stb.selWr  = 1'b1;
        end else begin
          stb.rdSrc = SRC_SEL;
        end
      end else if (busAddr == OFF_WINDOW) begin
        if (selCur == IDX_ID) begin
          if (busWrite) stb.idWr  = 1'b1;
          else          stb.rdSrc = SRC_ID;
        end else if (selCur == IDX_VER) begin
          if (!busWrite) stb.rdSrc = SRC_VER;
        end else if (selCur == IDX_ARB) begin
          if (!busWrite) stb.rdSrc = SRC_ZERO;
        end else if (inTable) begin
          stb.tblIdx = {1'b0, tblOff[7:1]};
          stb.tblHi  = tblOff[0];
          if (busWrite) stb.tblWr = 1'b1;
          else          stb.rdSrc = SRC_TBL;
        end else begin
          stb.rspErr = 1'b1;
        end
      end else begin
        stb.rspErr = 1'b1;
      end
    end

    if (irqValid) begin
      if (32'(irqLine) < NUM_ENTRIES) begin
        stb.lookup    = 1'b1;
        stb.lookupIdx = irqLine;
      end else begin
        stb.irqErr = 1'b1;
      end
    end
  end

endmodule

// File: rtl/irq_route_datapath.sv
module irq_route_datapath
  import irq_route_pkg::*;
#(
  parameter int NUM_ENTRIES = 24,
  parameter int DEST_W      = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStb_t          stb,
  input  logic [31:0]       busWdata,
  output logic [7:0]        selCur,
  output logic              respValid,
  output logic              respErr,
  output logic [31:0]       respData,
  output logic              dlvValid,
  output logic [7:0]        dlvVector,
  output logic [DEST_W-1:0] dlvDest,
  output logic              irqErr
);

  localparam logic [31:0] VER_WORD =
    (32'(NUM_ENTRIES - 1) << 16) & 32'h00FF_0000 | {24'd0, VER_CODE};

  logic [7:0]  selQ;
  logic [31:0] idQ;
  logic [31:0] tblLo [NUM_ENTRIES];
  logic [31:0] tblHi [NUM_ENTRIES];

  logic [31:0]       rdWord;
  logic [31:0]       tblRead;
  logic [7:0]        lkVec;
  logic              lkLogical;
  logic [7:0]        lkHiTop;
  logic [DEST_W-1:0] lkDest;

  assign selCur = selQ;

  // Bus-side table read.
  always_comb begin
    tblRead = '0;
    for (int k = 0; k < NUM_ENTRIES; k++) begin
      if (stb.tblIdx == 8'(k)) tblRead = stb.tblHi ? tblHi[k] : tblLo[k];
    end
  end

  always_comb begin
    unique case (stb.rdSrc)
      SRC_SEL:  rdWord = {24'd0, selQ};
      SRC_ID:   rdWord = idQ;
      SRC_VER:  rdWord = VER_WORD;
      SRC_TBL:  rdWord = tblRead;
      default:  rdWord = '0;
    endcase
  end

  // Interrupt-side entry lookup (reads the pre-write contents).
  always_comb begin
    lkVec     = '0;
    lkLogical = 1'b0;
    lkHiTop   = '0;
    for (int k = 0; k < NUM_ENTRIES; k++) begin
      if (stb.lookupIdx == 8'(k)) begin
        lkVec     = tblLo[k][7:0];
        lkLogical = tblLo[k][11];
        lkHiTop   = tblHi[k][31:24];
      end
    end
  end

  generate
    if (DEST_W >= 16) begin : g_wideDest
      always_comb begin
        if (lkLogical) lkDest = DEST_W'(lkHiTop);
        else           lkDest = DEST_W'(1) << lkHiTop[3:0];
      end
    end else begin : g_narrowDest
      always_comb begin
        if (lkLogical) lkDest = DEST_W'(lkHiTop);
        else           lkDest = DEST_W'(1) << lkHiTop[2:0];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      selQ <= '0;
      idQ  <= '0;
      for (int k = 0; k < NUM_ENTRIES; k++) begin
        tblLo[k] <= '0;
        tblHi[k] <= '0;
      end
    end else begin
      if (stb.selWr) selQ <= busWdata[7:0];
      if (stb.idWr)  idQ  <= busWdata;
      for (int k = 0; k < NUM_ENTRIES; k++) begin
        if (stb.tblWr && stb.tblIdx == 8'(k)) begin
          if (stb.tblHi) tblHi[k] <= busWdata;
          else           tblLo[k] <= busWdata;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      respValid <= 1'b0;
      respErr   <= 1'b0;
      respData  <= '0;
      dlvValid  <= 1'b0;
      dlvVector <= '0;
      dlvDest   <= '0;
      irqErr    <= 1'b0;
    end else begin
      respValid <= stb.rspValid;
      respErr   <= stb.rspErr;
      respData  <= stb.rspErr ? 32'd0 : rdWord;
      dlvValid  <= stb.lookup;
      dlvVector <= stb.lookup ? lkVec  : 8'd0;
      dlvDest   <= stb.lookup ? lkDest : '0;
      irqErr    <= stb.irqErr;
    end
  end

endmodule

// File: rtl/irq_route_ctrl.sv
module irq_route_ctrl
  import irq_route_pkg::*;
#(
  parameter int NUM_ENTRIES = 24,
  parameter int DEST_W      = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busValid,
  input  logic              busWrite,
  input  logic [7:0]        busAddr,
  input  logic [31:0]       busWdata,
  output logic              respValid,
  output logic              respErr,
  output logic [31:0]       respData,
  input  logic              irqValid,
  input  logic [7:0]        irqLine,
  output logic              dlvValid,
  output logic [7:0]        dlvVector,
  output logic [DEST_W-1:0] dlvDest,
  output logic              irqErr
);

  ctrlStb_t   stb;
  logic [7:0] selCur;

  irq_route_decode #(.NUM_ENTRIES(NUM_ENTRIES)) u_decode (
    .busValid (busValid),
    .busWrite (busWrite),
    .busAddr  (busAddr),
    .busWdata (busWdata),
    .selCur   (selCur),
    .irqValid (irqValid),
    .irqLine  (irqLine),
    .stb      (stb)
  );

  irq_route_datapath #(.NUM_ENTRIES(NUM_ENTRIES), .DEST_W(DEST_W)) u_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .busWdata  (busWdata),
    .selCur    (selCur),
    .respValid (respValid),
    .respErr   (respErr),
    .respData  (respData),
    .dlvValid  (dlvValid),
    .dlvVector (dlvVector),
    .dlvDest   (dlvDest),
    .irqErr    (irqErr)
  );

endmodule

// File: rtl/irq_route_ctrl_chk.sv
module irq_route_ctrl_chk #(
  parameter int NUM_ENTRIES = 24
) (
  input logic        clk,
  input logic        rstN,
  input logic        busValid,
  input logic        busWrite,
  input logic [7:0]  busAddr,
  input logic [31:0] busWdata,
  input logic        respValid,
  input logic        respErr,
  input logic [31:0] respData,
  input logic        irqValid,
  input logic [7:0]  irqLine,
  input logic        dlvValid,
  input logic        irqErr,
  input logic [7:0]  selCur
);

  // R14
  rsp_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    busValid |=> respValid);

  // R14
  rsp_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busValid |=> !respValid);

  // R2
  err_data_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    respErr |-> (respValid && respData == 32'd0));

  // R2
  bad_offset_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && busAddr != 8'h00 && busAddr != 8'h10) |=> respErr);

  // R3
  sel_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && busWrite && busAddr == 8'h00 && busWdata > 32'd255)
      |=> (respErr && selCur == $past(selCur)));

  // R9
  dlv_issue_chk: assert property (@(posedge clk) disable iff (!rstN)
    (irqValid && 32'(irqLine) < NUM_ENTRIES) |=> (dlvValid && !irqErr));

  // R12
  irq_reject_chk: assert property (@(posedge clk) disable iff (!rstN)
    (irqValid && 32'(irqLine) >= NUM_ENTRIES) |=> (irqErr && !dlvValid));

  // R12
  irq_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !irqValid |=> (!irqErr && !dlvValid));

endmodule

bind irq_route_ctrl irq_route_ctrl_chk #(.NUM_ENTRIES(NUM_ENTRIES)) u_chk (.*);

// File: tb/irq_route_ctrl_tb.sv
`timescale 1ns/1ps
module irq_route_ctrl_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busValid = 1'b0;
  logic        busWrite = 1'b0;
  logic [7:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic        respValid;
  logic        respErr;
  logic [31:0] respData;
  logic        irqValid = 1'b0;
  logic [7:0]  irqLine = '0;
  logic        dlvValid;
  logic [7:0]  dlvVector;
  logic [15:0] dlvDest;
  logic        irqErr;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  irq_route_ctrl #(.NUM_ENTRIES(24), .DEST_W(16)) u_dut (
    .clk(clk), .rstN(rstN),
    .busValid(busValid), .busWrite(busWrite), .busAddr(busAddr), .busWdata(busWdata),
    .respValid(respValid), .respErr(respErr), .respData(respData),
    .irqValid(irqValid), .irqLine(irqLine),
    .dlvValid(dlvValid), .dlvVector(dlvVector), .dlvDest(dlvDest), .irqErr(irqErr)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  // One bus access; returns error flag and read data; checks R14 timing.
  task automatic busOp(input bit wr, input logic [7:0] addr, input logic [31:0] data,
                       output logic err, output logic [31:0] rd);
    @(negedge clk);
    busValid = 1'b1; busWrite = wr; busAddr = addr; busWdata = data;
    @(posedge clk); #1;
    chk("R14 resp present", {31'd0, respValid}, 32'd1);
    err = respErr; rd = respData;
    @(negedge clk);
    busValid = 1'b0; busWrite = 1'b0;
    @(posedge clk); #1;
    chk("R14 resp single", {31'd0, respValid}, 32'd0);
  endtask

  task automatic wrReg(input logic [7:0] idx, input logic [31:0] val, output logic err);
    logic e; logic [31:0] r;
    busOp(1'b1, 8'h00, {24'd0, idx}, e, r);
    busOp(1'b1, 8'h10, val, err, r);
  endtask

  task automatic rdReg(input logic [7:0] idx, output logic err, output logic [31:0] val);
    logic e; logic [31:0] r;
    busOp(1'b1, 8'h00, {24'd0, idx}, e, r);
    busOp(1'b0, 8'h10, 32'd0, err, val);
  endtask

  task automatic irqOp(input logic [7:0] line, output logic v, output logic [7:0] vec,
                       output logic [15:0] dst, output logic e);
    @(negedge clk);
    irqValid = 1'b1; irqLine = line;
    @(posedge clk); #1;
    v = dlvValid; vec = dlvVector; dst = dlvDest; e = irqErr;
    @(negedge clk);
    irqValid = 1'b0;
  endtask

  task automatic testReset();
    logic e; logic [31:0] r;
    busOp(1'b0, 8'h00, 32'd0, e, r);
    chk("R1 select zero", r, 32'd0);
    rdReg(8'h00, e, r);
    chk("R1 id zero", r, 32'd0);
    rdReg(8'h1B, e, r);
    chk("R1 table zero", r, 32'd0);
  endtask

  task automatic testOffsets();
    logic e; logic [31:0] r;
    busOp(1'b1, 8'h00, 32'h00000002, e, r);
    busOp(1'b1, 8'h08, 32'h00000055, e, r);
    chk("R2 bad offset write err", {31'd0, e}, 32'd1);
    busOp(1'b0, 8'h14, 32'd0, e, r);
    chk("R2 bad offset read err", {31'd0, e}, 32'd1);
    chk("R2 bad offset data", r, 32'd0);
    busOp(1'b0, 8'h00, 32'd0, e, r);
    chk("R2 select untouched", r, 32'h2);
  endtask

  task automatic testSelect();
    logic e; logic [31:0] r;
    busOp(1'b1, 8'h00, 32'h000000FF, e, r);
    chk("R3 select 255 ok", {31'd0, e}, 32'd0);
    busOp(1'b1, 8'h00, 32'h00000100, e, r);
    chk("R3 select 256 err", {31'd0, e}, 32'd1);
    busOp(1'b0, 8'h00, 32'd0, e, r);
    chk("R3 select kept", r, 32'hFF);
  endtask

  task automatic testId();
    logic e; logic [31:0] r;
    wrReg(8'h00, 32'hDEADBEEF, e);
    rdReg(8'h00, e, r);
    chk("R4 id readback", r, 32'hDEADBEEF);
  endtask

  task automatic testVersion();
    logic e; logic [31:0] r;
    rdReg(8'h01, e, r);
    chk("R5 version value", r, 32'h00170011);
    wrReg(8'h01, 32'h55AA55AA, e);
    chk("R5 version write no err", {31'd0, e}, 32'd0);
    rdReg(8'h01, e, r);
    chk("R5 version unchanged", r, 32'h00170011);
    rdReg(8'h00, e, r);
    chk("R5 id unchanged", r, 32'hDEADBEEF);
  endtask

  task automatic testArb();
    logic e; logic [31:0] r;
    rdReg(8'h02, e, r);
    chk("R6 arb zero", r, 32'd0);
    wrReg(8'h02, 32'hFFFFFFFF, e);
    chk("R6 arb write no err", {31'd0, e}, 32'd0);
    rdReg(8'h02, e, r);
    chk("R6 arb still zero", r, 32'd0);
  endtask

  task automatic testTable();
    logic e; logic [31:0] r;
    wrReg(8'h10, 32'h00000031, e);
    wrReg(8'h11, 32'h05000000, e);
    wrReg(8'h3E, 32'h00000842, e);
    wrReg(8'h3F, 32'hAB000000, e);
    wrReg(8'h12, 32'h00000077, e);
    wrReg(8'h13, 32'hF3000000, e);
    rdReg(8'h10, e, r);
    chk("R7 entry0 low", r, 32'h31);
    rdReg(8'h11, e, r);
    chk("R7 entry0 high", r, 32'h05000000);
    rdReg(8'h3F, e, r);
    chk("R7 last entry high", r, 32'hAB000000);
    chk("R7 last entry no err", {31'd0, e}, 32'd0);
    rdReg(8'h3E, e, r);
    chk("R7 last entry low", r, 32'h842);
  endtask

  task automatic testUnmapped();
    logic e; logic [31:0] r;
    rdReg(8'h03, e, r);
    chk("R8 index 0x03 err", {31'd0, e}, 32'd1);
    rdReg(8'h40, e, r);
    chk("R8 index 0x40 err", {31'd0, e}, 32'd1);
    wrReg(8'h40, 32'h12345678, e);
    chk("R8 write 0x40 err", {31'd0, e}, 32'd1);
    rdReg(8'h3F, e, r);
    chk("R8 last entry untouched", r, 32'hAB000000);
    rdReg(8'h10, e, r);
    chk("R8 entry0 untouched", r, 32'h31);
  endtask

  task automatic testDelivery();
    logic v, e; logic [7:0] vec; logic [15:0] d;
    irqOp(8'd0, v, vec, d, e);
    chk("R9 line0 valid", {31'd0, v}, 32'd1);
    chk("R9 line0 vector", {24'd0, vec}, 32'h31);
    chk("R10 line0 physical dest", {16'd0, d}, 32'h0020);
    chk("R9 line0 no err", {31'd0, e}, 32'd0);
    @(posedge clk); #1;
    chk("R9 pulse single", {31'd0, dlvValid}, 32'd0);
    irqOp(8'd1, v, vec, d, e);
    chk("R10 upper id bits ignored", {16'd0, d}, 32'h0008);
    irqOp(8'd23, v, vec, d, e);
    chk("R11 logical vector", {24'd0, vec}, 32'h42);
    chk("R11 logical dest", {16'd0, d}, 32'h00AB);
  endtask

  task automatic testReject();
    logic v, e; logic [7:0] vec; logic [15:0] d;
    irqOp(8'd24, v, vec, d, e);
    chk("R12 line24 err", {31'd0, e}, 32'd1);
    chk("R12 line24 no dlv", {31'd0, v}, 32'd0);
    irqOp(8'd255, v, vec, d, e);
    chk("R12 line255 err", {31'd0, e}, 32'd1);
    chk("R12 line255 no dlv", {31'd0, v}, 32'd0);
  endtask

  task automatic testCollision();
    logic e, v; logic [31:0] r; logic [7:0] vec; logic [15:0] d;
    busOp(1'b1, 8'h00, 32'h00000010, e, r);
    @(negedge clk);
    busValid = 1'b1; busWrite = 1'b1; busAddr = 8'h10; busWdata = 32'h000000C5;
    irqValid = 1'b1; irqLine = 8'd0;
    @(posedge clk); #1;
    chk("R13 collision old vector", {24'd0, dlvVector}, 32'h31);
    @(negedge clk);
    busValid = 1'b0; busWrite = 1'b0; irqValid = 1'b0;
    irqOp(8'd0, v, vec, d, e);
    chk("R13 new vector after", {24'd0, vec}, 32'hC5);
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    @(posedge clk); #1;
    chk("R14 idle after reset", {31'd0, respValid}, 32'd0);
    testReset();
    testOffsets();
    testSelect();
    testId();
    testVersion();
    testArb();
    testTable();
    testUnmapped();
    testDelivery();
    testReject();
    testCollision();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule